// File: doc/BRIEF.md
# Selectable Interrupt Request Line Driver

This block routes a single internal interrupt-pending flag onto one of six bus interrupt lines. Each line leaves the block as a pair of signals, a drive value and an output enable, meant for a tristate pad. A 3-bit line code, an enable bit and a mode bit select both the active line and its signalling style. In push-pull (edge) style the chosen line is driven high while an interrupt is pending and driven low otherwise. In open-drain (level) style the chosen line is pulled low while an interrupt is pending and released otherwise.

Every line that is not chosen is left at high impedance, whatever the pending flag says. All inputs are captured on the rising clock edge, so the pads follow the inputs one cycle later. The bus reset takes effect at once: while it is high, every output enable is forced low in the same cycle, with no wait for a clock edge.

Top module: `irq_line_router`

## Requirements
- R1: While `rst` is 1, every bit of `line_oe_o` and `line_drv_o` is 0 in that same cycle, with no clock edge needed. After `rst` falls they stay 0 until the first rising edge at which `rst` is low.
- R2: At no time is more than one bit of `line_oe_o` set.
- R3: When edge mode (`level_mode_i`=0), enable 1, code n in 0..5 and pending 1 are sampled, the next cycle shows `line_oe_o[n]`=1 and `line_drv_o[n]`=1.
- R4: When edge mode, enable 1, code n in 0..5 and pending 0 are sampled, the next cycle shows `line_oe_o[n]`=1 and `line_drv_o[n]`=0.
- R5: When level mode (`level_mode_i`=1), enable 1, code n in 0..5 and pending 1 are sampled, the next cycle shows `line_oe_o[n]`=1 and `line_drv_o[n]`=0.
- R6: When level mode, enable 1, a valid code and pending 0 are sampled, the next cycle shows `line_oe_o` all 0.
- R7: A line whose index differs from the sampled code has oe 0 and drive 0 in the next cycle, whatever the pending flag is. Code n selects bit n.
- R8: A sampled code of 6 or 7, or a sampled enable of 0, gives all-zero `line_oe_o` and `line_drv_o` in the next cycle.
- R9: The outputs reflect only the inputs sampled at the latest rising edge. Input changes between edges have no effect until the next edge.
- R10: Changing the code or the mode between two consecutive edges moves the drive from one line to another in a single step, with no cycle in which two lines are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high bus reset: synchronous for the state, immediate on the pads |
| irq_pending_i | input | 1 | Internal interrupt-pending flag |
| line_sel_i | input | 3 | Line code: 0..5 choose a line, 6 and 7 choose none |
| level_mode_i | input | 1 | 0 = push-pull edge style, 1 = open-drain level style |
| enable_i | input | 1 | 1 enables the selected line |
| line_drv_o | output | 6 | Per-line drive value for the pad |
| line_oe_o | output | 6 | Per-line output enable for the pad |

## Verification
Reset and a line reselection can land in the same cycle. The bench drives a valid configuration, then raises `rst` between edges while also changing the code. It checks that the enables drop at once and that, after release, the new line shows up only one edge later. Pending toggles and mode changes also land on the same edge as reselection. These are judged against a bench model of the next-cycle pad pair, and the one-hot rule is checked every cycle.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int IRQ_NUM_LINES = 6;
  localparam int IRQ_SEL_W     = 3;

  typedef enum logic {
    IRQ_EDGE  = 1'b0,
    IRQ_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/irq_onehot_dec.sv
module irq_onehot_dec #(
  parameter int NUM_LINES = 6,
  parameter int SEL_W     = 3
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 en,
  output logic [NUM_LINES-1:0] hit
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    localparam logic [SEL_W-1:0] CODE = SEL_W'(g);
    assign hit[g] = en && (sel == CODE);
  end

  always_comb begin
    // R2
    onehot_dec_chk: assert ($onehot0(hit) || $isunknown(hit));
  end
endmodule

// File: rtl/irq_pad_ctrl.sv
module irq_pad_ctrl
  import irq_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  logic      pending,
  input  irq_mode_e mode,
  output logic      drv_q,
  output logic      oe_q
);
  logic drv_d, oe_d;

  always_comb begin
    drv_d = 1'b0;
    oe_d  = 1'b0;
    if (hit) begin
      if (mode == IRQ_EDGE) begin
        oe_d  = 1'b1;
        drv_d = pending;
      end else begin
        oe_d  = pending;
        drv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      drv_q <= drv_d;
      oe_q  <= oe_d;
    end
  end

  // R5
  level_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && mode == IRQ_LEVEL) |=> !drv_q);

  // R7
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (!oe_q && !drv_q));
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_sel_pkg::*;
#(
  parameter int NUM_LINES = IRQ_NUM_LINES,
  parameter int SEL_W     = IRQ_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 irq_pending_i,
  input  logic [SEL_W-1:0]     line_sel_i,
  input  logic                 level_mode_i,
  input  logic                 enable_i,
  output logic [NUM_LINES-1:0] line_drv_o,
  output logic [NUM_LINES-1:0] line_oe_o
);
  localparam logic [NUM_LINES-1:0] ONE_LINE = NUM_LINES'(1);

  irq_mode_e            mode_w;
  logic [NUM_LINES-1:0] hit_w;
  logic [NUM_LINES-1:0] drv_q, oe_q;

  assign mode_w = irq_mode_e'(level_mode_i);

  irq_onehot_dec #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_dec (
    .sel (line_sel_i),
    .en  (enable_i),
    .hit (hit_w)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_pad_ctrl u_pad (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_w[g]),
      .pending (irq_pending_i),
      .mode    (mode_w),
      .drv_q   (drv_q[g]),
      .oe_q    (oe_q[g])
    );
  end

  // Reset releases the pads in the same cycle, without waiting for an edge.
  assign line_oe_o  = rst ? '0 : oe_q;
  assign line_drv_o = rst ? '0 : drv_q;

  always_comb begin
    if (rst === 1'b1) begin
      // R1
      reset_hiz_chk: assert (line_oe_o == '0);
    end
  end

  // R2
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_oe_o));

  // R3
  edge_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && !level_mode_i && irq_pending_i && line_sel_i < SEL_W'(NUM_LINES))
    |=> (line_oe_o == (ONE_LINE << $past(line_sel_i)) &&
         line_drv_o == (ONE_LINE << $past(line_sel_i))));

  // R4
  edge_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && !level_mode_i && !irq_pending_i && line_sel_i < SEL_W'(NUM_LINES))
    |=> (line_oe_o == (ONE_LINE << $past(line_sel_i)) && line_drv_o == '0));

  // R6
  level_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (enable_i && level_mode_i && !irq_pending_i) |=> (line_oe_o == '0));

  // R8
  no_line_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable_i || line_sel_i >= SEL_W'(NUM_LINES)) |=> (line_oe_o == '0 && line_drv_o == '0));
endmodule

// File: tb/irq_line_router_test.sv
module irq_line_router_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       pend;
  logic [2:0] sel;
  logic       lvl;
  logic       en;
  logic [5:0] drv, oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_line_router uut (
    .clk(clk), .rst(rst), .irq_pending_i(pend), .line_sel_i(sel),
    .level_mode_i(lvl), .enable_i(en), .line_drv_o(drv), .line_oe_o(oe)
  );

  function automatic logic [5:0] exp_oe(logic [2:0] s, logic m, logic e, logic p);
    if (!e || s > 3'd5) return 6'd0;
    if (m && !p) return 6'd0;
    return 6'd1 << s;
  endfunction

  function automatic logic [5:0] exp_drv(logic [2:0] s, logic m, logic e, logic p);
    if (!e || s > 3'd5 || m || !p) return 6'd0;
    return 6'd1 << s;
  endfunction

  task automatic check(string req, logic [5:0] a_oe, logic [5:0] a_drv,
                       logic [5:0] e_oe, logic [5:0] e_drv);
    checks++;
    if (a_oe !== e_oe || a_drv !== e_drv) begin
      fails++;
      $display("FAIL %s oe=%b drv=%b expected oe=%b drv=%b", req, a_oe, a_drv, e_oe, e_drv);
    end
  endtask

  task automatic apply_and_check(string req, logic [2:0] s, logic m, logic e, logic p);
    sel = s; lvl = m; en = e; pend = p;
    @(negedge clk);
    check(req, oe, drv, exp_oe(s, m, e, p), exp_drv(s, m, e, p));
    checks++;
    if (!$onehot0(oe)) begin
      fails++;
      $display("FAIL R2 oe=%b expected at most one bit", oe);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired oe=%b expected run to finish", oe);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; pend = 1'b1; sel = 3'd2; lvl = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", oe, drv, 6'd0, 6'd0);

    // R1: release with no edge yet -> still quiet
    rst = 1'b0; #1;
    check("R1 release", oe, drv, 6'd0, 6'd0);
    @(negedge clk);
    check("R3 first", oe, drv, 6'b000100, 6'b000100);

    // R3 R4 R5 R6 R7 across every code and both modes
    for (int c = 0; c < 8; c++) begin
      apply_and_check("R3", 3'(c), 1'b0, 1'b1, 1'b1);
      apply_and_check("R4", 3'(c), 1'b0, 1'b1, 1'b0);
      apply_and_check("R5", 3'(c), 1'b1, 1'b1, 1'b1);
      apply_and_check("R6", 3'(c), 1'b1, 1'b1, 1'b0);
    end
    // R8 disable and invalid codes
    apply_and_check("R8 disabled", 3'd3, 1'b0, 1'b0, 1'b1);
    apply_and_check("R8 code6", 3'd6, 1'b0, 1'b1, 1'b1);
    apply_and_check("R8 code7", 3'd7, 1'b1, 1'b1, 1'b1);

    // R10 line hop each cycle in edge mode, with a mode flip
    for (int c = 0; c < 6; c++) apply_and_check("R10 hop", 3'(5 - c), 1'b0, 1'b1, 1'b0);
    apply_and_check("R10 mode", 3'd0, 1'b1, 1'b1, 1'b1);
    apply_and_check("R10 mode back", 3'd4, 1'b0, 1'b1, 1'b1);

    // R9: mid-cycle input wiggle has no effect until the next edge
    apply_and_check("R9 base", 3'd1, 1'b0, 1'b1, 1'b1);
    sel = 3'd4; pend = 1'b0; #1;
    check("R9 hold", oe, drv, 6'b000010, 6'b000010);
    @(negedge clk);
    check("R9 take", oe, drv, 6'b010000, 6'b000000);

    // R1 reset while reselecting: pads drop at once
    sel = 3'd5; pend = 1'b1; lvl = 1'b0; en = 1'b1;
    rst = 1'b1; #1;
    check("R1 immediate", oe, drv, 6'd0, 6'd0);
    @(negedge clk);
    rst = 1'b0; #1;
    check("R1 after", oe, drv, 6'd0, 6'd0);
    @(negedge clk);
    check("R1 resume", oe, drv, 6'b100000, 6'b100000);

    // Random traffic, R7 and R2 on every step
    for (int i = 0; i < 400; i++) begin
      apply_and_check("R7 random", 3'($urandom_range(7)), 1'($urandom_range(1)),
                      ($urandom_range(7) != 0), 1'($urandom_range(1)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule